// File: doc/BRIEF.md
# Constant-Fraction Pulse Timing Extractor

The block takes one window of digitized waveform samples, one sample per clock, and reports the arrival time of the pulse in that window. Each sample first has a fixed pedestal removed. The corrected values go into an internal buffer while the block tracks the largest value and its position. When the window closes, the block sets a threshold at a programmable fraction of that peak. Because every pulse gets its own threshold, the reported time does not shift with pulse amplitude.

The block then walks backwards from the peak along the leading edge. It looks for the last pair of neighbouring samples whose values enclose the threshold. A bit-serial divider interpolates linearly between the two samples. The result is a sample index with eight fractional bits. If the block finds no crossing, it raises an error pulse instead of a valid pulse.

The controller has five states:
- IDLE: waits for a sample marked as the first of a window.
- CAPTURE: stores samples until the window closes.
- THRESH: computes the threshold and checks the peak position.
- SCAN: checks one index per clock, walking down from the peak.
- DIVIDE: waits for the fraction.

The transitions are:
- start (IDLE to CAPTURE, or IDLE straight to THRESH for a one-sample window).
- close (CAPTURE to THRESH).
- edge_peak (THRESH to IDLE with an error).
- search (THRESH to SCAN).
- hit (SCAN to DIVIDE).
- miss (SCAN to IDLE with an error, once index 0 has failed).
- finish (DIVIDE to IDLE with valid).

Top module: `cfd_timer`

## Requirements
- R1: Each accepted sample is corrected to in_sample minus pedestal, or to 0 when in_sample is not above pedestal. All searches use the corrected values.
- R2: The peak is the first sample in the window that holds the largest corrected value. Its index counts from 0 at the sample marked in_first.
- R3: The threshold is floor(peak × frac_k / 65536), where frac_k is unsigned with 16 fractional bits. Scaling a pulse by an integer factor leaves the reported time unchanged whenever the scaled threshold scales exactly.
- R4: The crossing is the largest index i below the peak index for which c[i] < threshold ≤ c[i+1]. Earlier crossings are ignored.
- R5: t_time equals i×256 + floor((threshold − c[i])×256 / (c[i+1] − c[i])). The upper bits hold the index and the low 8 bits hold the fraction. A threshold equal to c[i+1] gives exactly (i+1)×256.
- R6: t_error pulses, and t_valid stays low, when the peak is at index 0 or when no index below the peak satisfies R4.
- R7: Let T0 be the clock edge that accepts the last sample, and m the peak index minus the crossing index.
  - t_valid is high for one cycle after edge T0+m+11.
  - When the peak is at index 0, t_error is high for one cycle after edge T0+1.
  - When there is no crossing, t_error is high for one cycle after edge T0+1+peak index.
  - At all other times both outputs are low.
- R8: A window opens with in_valid and in_first while the block is idle. It closes on a sample with in_last, or automatically on its 64th sample. In_valid samples arriving while idle without in_first, or after the window has closed, are ignored.
- R9: After reset, t_valid and t_error are low, t_time is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_first | input | 1 | Marks the first sample of a window |
| in_last | input | 1 | Marks the last sample of a window |
| in_sample | input | DW (12) | Raw unsigned sample |
| pedestal | input | DW (12) | Baseline removed from every sample |
| frac_k | input | KW (16) | Threshold fraction, 0 to just below 1 |
| t_valid | output | 1 | One-cycle pulse: t_time holds a new result |
| t_error | output | 1 | One-cycle pulse: no usable crossing |
| t_time | output | IW+FW (14) | Crossing time: index and 8 fractional bits |

## Verification
All result timing is counted from the clock edge that accepts a window's last sample. The error for a peak at index 0 is due one cycle later. A missing crossing is reported peak-index plus one cycles later. A valid time is reported eleven cycles plus the backwards search distance later. The bench works out that cycle from its own model of the window. It then compares t_valid and t_error against the expected values on every cycle from that edge to one cycle past the expected result. It compares t_time only in the cycle the pulse is due, so an early, late or doubled pulse is reported. Input samples fed in during processing test that ignored input does not move the result or its cycle.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_THRESH,
        ST_SCAN,
        ST_DIVIDE
    } cfd_state_t;
endpackage

// File: rtl/cfd_buf.sv
module cfd_buf #(
    parameter int DW  = 12,
    parameter int WIN = 64,
    parameter int IW  = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata_lo,
    output logic [DW-1:0] rdata_hi
);
    logic [DW-1:0] mem [WIN];
    logic [IW-1:0] raddr_nx;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign raddr_nx = raddr + 1'b1;
    assign rdata_lo = mem[raddr];
    assign rdata_hi = mem[raddr_nx];
endmodule

// File: rtl/cfd_div.sv
module cfd_div #(
    parameter int DW = 12,
    parameter int FW = 8,
    localparam int CW = $clog2(FW + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [FW:0]   quo
);
    logic [DW:0]   rem;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt;
    logic          busy;
    logic          ge;
    logic [DW:0]   diff;

    assign ge   = rem >= {1'b0, den_q};
    assign diff = ge ? rem - {1'b0, den_q} : rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            quo   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem   <= {1'b0, num};
                den_q <= den;
                cnt   <= CW'(FW + 1);
                busy  <= 1'b1;
                quo   <= '0;
            end else if (busy) begin
                rem <= diff << 1;
                quo <= {quo[FW-1:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R5: a fraction never exceeds one full sample step
    assert_quotient_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quo <= (FW+1)'(1 << FW)));
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer
    import cfd_pkg::*;
#(
    parameter int DW  = 12,
    parameter int WIN = 64,
    parameter int KW  = 16,
    parameter int FW  = 8,
    localparam int IW = $clog2(WIN),
    localparam int TW = IW + FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic          in_last,
    input  logic [DW-1:0] in_sample,
    input  logic [DW-1:0] pedestal,
    input  logic [KW-1:0] frac_k,
    output logic          t_valid,
    output logic          t_error,
    output logic [TW-1:0] t_time
);
    cfd_state_t state_q, state_d;

    logic [IW-1:0]    wr_cnt, wr_addr, peak_idx, scan_idx;
    logic [DW-1:0]    peak_val, thr_q, corr, s_lo, s_hi, thr_calc;
    logic [DW+KW-1:0] prod;
    logic             accept, last_now, hit, div_start, div_done;
    logic [FW:0]      quo;

    // R1: pedestal removal with clamp
    assign corr     = (in_sample > pedestal) ? in_sample - pedestal : '0;
    assign accept   = in_valid && ((state_q == ST_IDLE && in_first) || state_q == ST_CAPTURE);
    assign wr_addr  = (state_q == ST_IDLE) ? '0 : wr_cnt;
    assign last_now = accept && (in_last || wr_addr == IW'(WIN - 1));

    // R3: threshold as a fraction of the peak
    assign prod     = (DW+KW)'(peak_val) * (DW+KW)'(frac_k);
    assign thr_calc = DW'(prod >> KW);

    // R4: straddle test on the current scan pair
    assign hit       = (s_lo < thr_q) && (thr_q <= s_hi);
    assign div_start = (state_q == ST_SCAN) && hit;

    cfd_buf #(.DW(DW), .WIN(WIN), .IW(IW)) u_buf (
        .clk      (clk),
        .we       (accept),
        .waddr    (wr_addr),
        .wdata    (corr),
        .raddr    (scan_idx),
        .rdata_lo (s_lo),
        .rdata_hi (s_hi)
    );

    cfd_div #(.DW(DW), .FW(FW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (thr_q - s_lo),
        .den   (s_hi - s_lo),
        .done  (div_done),
        .quo   (quo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = last_now ? ST_THRESH : ST_CAPTURE;
            ST_CAPTURE: if (last_now) state_d = ST_THRESH;
            ST_THRESH:  state_d = (peak_idx == '0) ? ST_IDLE : ST_SCAN;
            ST_SCAN: begin
                if (hit)                  state_d = ST_DIVIDE;
                else if (scan_idx == '0)  state_d = ST_IDLE;
            end
            ST_DIVIDE:  if (div_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt   <= '0;
            peak_val <= '0;
            peak_idx <= '0;
            thr_q    <= '0;
            scan_idx <= '0;
            t_valid  <= 1'b0;
            t_error  <= 1'b0;
            t_time   <= '0;
        end else begin
            t_valid <= 1'b0;
            t_error <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_CAPTURE: begin
                    if (accept) begin
                        wr_cnt <= wr_addr + 1'b1;
                        // R2: first occurrence of the largest value wins
                        if (state_q == ST_IDLE || corr > peak_val) begin
                            peak_val <= corr;
                            peak_idx <= wr_addr;
                        end
                    end
                end
                ST_THRESH: begin
                    thr_q    <= thr_calc;
                    scan_idx <= peak_idx - 1'b1;
                    if (peak_idx == '0) t_error <= 1'b1;
                end
                ST_SCAN: begin
                    if (!hit) begin
                        if (scan_idx == '0) t_error <= 1'b1;
                        else                scan_idx <= scan_idx - 1'b1;
                    end
                end
                ST_DIVIDE: begin
                    if (div_done) begin
                        t_valid <= 1'b1;
                        t_time  <= {scan_idx, {FW{1'b0}}} + TW'(quo);
                    end
                end
                default: ;
            endcase
        end
    end

    assert_exclusive_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_valid && t_error));
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        t_valid |=> !t_valid);
    assert_error_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        t_error |=> !t_error);
    assert_scan_below_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (scan_idx < peak_idx));
    assert_thr_not_above_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (thr_q <= peak_val));
endmodule

// File: tb/test_cfd_timer.sv
module test_cfd_timer;
    localparam int DW = 12, WIN = 64, KW = 16, FW = 8;
    localparam int TW = $clog2(WIN) + FW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_first = 0, in_last = 0;
    logic [DW-1:0] in_sample = '0, pedestal = '0;
    logic [KW-1:0] frac_k = '0;
    logic t_valid, t_error;
    logic [TW-1:0] t_time;

    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    cfd_timer #(.DW(DW), .WIN(WIN), .KW(KW), .FW(FW)) i_cfd_timer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_sample(in_sample), .pedestal(pedestal),
        .frac_k(frac_k), .t_valid(t_valid), .t_error(t_error), .t_time(t_time)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Feeds one window, models the result behaviourally and compares every cycle.
    task automatic run_window(input int s[$], input int ped, input int k,
                              input bit junk, input bit use_last, input string tag,
                              output int got);
        int c[$];
        int pk, pi, thr, found, lat, kind, etime, n;
        n = s.size();
        foreach (s[j]) c.push_back(s[j] > ped ? s[j] - ped : 0);
        pk = -1; pi = 0;
        foreach (c[j]) if (c[j] > pk) begin pk = c[j]; pi = j; end
        thr = (pk * k) >>> 16;
        found = -1; etime = 0;
        if (pi == 0) begin kind = 1; lat = 1; end
        else begin
            for (int i = pi - 1; i >= 0; i--)
                if (found < 0 && c[i] < thr && thr <= c[i+1]) found = i;
            if (found < 0) begin kind = 1; lat = 1 + pi; end
            else begin
                kind = 0;
                lat = (pi - found) + FW + 3;
                etime = found * 256 + ((thr - c[found]) * 256) / (c[found+1] - c[found]);
            end
        end
        got = -1;
        @(negedge clk);
        pedestal = DW'(ped); frac_k = KW'(k);
        for (int j = 0; j < n; j++) begin
            if (j > 0) @(negedge clk);
            in_valid = 1; in_first = (j == 0); in_last = use_last && (j == n - 1);
            in_sample = DW'(s[j]);
        end
        for (int t = 0; t <= lat + 1; t++) begin
            @(negedge clk);
            check(t_valid == (kind == 0 && t == lat), "R7", "t_valid", int'(t_valid), int'(kind == 0 && t == lat));
            check(t_error == (kind == 1 && t == lat), kind == 1 ? "R6" : "R7", "t_error", int'(t_error), int'(kind == 1 && t == lat));
            if (kind == 0 && t == lat) begin
                got = int'(t_time);
                check(got == etime, tag, "t_time", got, etime);
            end
            if (junk && t + 1 <= lat - 1) begin
                in_valid = 1; in_first = 1; in_last = t[0]; in_sample = '1;
            end else begin
                in_valid = 0; in_first = 0; in_last = 0;
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int r, ra, rb;
        int q[$];
        repeat (3) @(negedge clk);
        // R9: reset state
        check(t_valid == 0, "R9", "t_valid", int'(t_valid), 0);
        check(t_error == 0, "R9", "t_error", int'(t_error), 0);
        check(t_time == 0, "R9", "t_time", int'(t_time), 0);
        rst_n = 1;
        // R8: idle samples without the start marker are ignored
        repeat (4) begin
            @(negedge clk); in_valid = 1; in_first = 0; in_sample = '1;
        end
        @(negedge clk); in_valid = 0;
        // R1 R5: typical pulse with pedestal, expected 1168
        run_window('{10,10,10,20,60,140,200,180,100,40}, 10, 32768, 0, 1, "R5", r);
        check(r == 1168, "R1", "pulse time", r, 1168);
        // R8: same pulse with input noise while busy
        run_window('{10,10,10,20,60,140,200,180,100,40}, 10, 32768, 1, 1, "R8", r);
        check(r == 1168, "R8", "time with junk", r, 1168);
        // R1: samples under the pedestal clamp to zero
        run_window('{30,40,50,90,170,250,210}, 50, 32768, 0, 1, "R1", r);
        // R2: equal peaks, first one counts
        run_window('{0,50,100,100,20}, 0, 32768, 0, 1, "R2", r);
        // R5: threshold equals the upper sample, expected 256
        run_window('{0,40,80,80}, 0, 32768, 0, 1, "R5", r);
        check(r == 256, "R5", "exact crossing", r, 256);
        // R6: peak at index 0
        run_window('{200,100,50}, 0, 32768, 0, 1, "R6", r);
        // R6: zero fraction means no crossing
        run_window('{0,20,60,120,90}, 0, 0, 0, 1, "R6", r);
        // R4: latest of two crossings
        run_window('{0,80,20,90,150,200}, 0, 26214, 0, 1, "R4", r);
        check(r == 2 * 256 + ((79 - 20) * 256) / 70, "R4", "latest crossing", r, 2 * 256 + ((79 - 20) * 256) / 70);
        // R3: doubled amplitude gives the same time
        run_window('{0,10,30,60,100,80}, 0, 32768, 0, 1, "R3", ra);
        run_window('{0,20,60,120,200,160}, 0, 32768, 0, 1, "R3", rb);
        check(ra == rb, "R3", "walk-free time", rb, ra);
        // R8: full window closes without in_last
        for (int j = 0; j < WIN; j++) q.push_back(j < 40 ? 5 + j * 9 : 400 - (j - 40) * 7);
        run_window(q, 5, 45000, 0, 0, "R8", r);
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule